// File: doc/BRIEF.md
# Edge-Interrupt GPIO Bank

This block is one bank of 32 general-purpose pins, grouped as four 8-bit ports and controlled through a small 32-bit register window. The window has byte-lane write strobes and separate read and write requests. Each pin can be set as an input or an output, and can be handed to a dedicated peripheral through a function-select bit. A data register drives the output latch. Reads of that register return the live level of input pins and the latch value of output pins.

Every input passes through a two-flop synchroniser and then through an edge detector. A 2-bit field per pin selects which edges raise a pending flag: none, falling, rising or both. The same field also acts as the interrupt enable. Pending flags are cleared by writing a one to them. All pending flags are ORed together and registered into a single interrupt line.

Software sees the ports in byte-address order, so the first port sits in the most significant byte of each word. The pairs of mode fields are half-word swapped to match that order.

Top module: `gpio_edge_bank`

## Requirements
- R1: After reset, every register reads as zero. `pin_oe`, `pin_func` and `pin_out` are all zero and `irq` is low, so every pin is a normal-function input with its interrupt disabled.
- R2: The word offsets are:
  - 0x00: function select.
  - 0x08: direction.
  - 0x0C: data.
  - 0x10: pending status.
  - 0x14: mode for pins 0-15.
  - 0x18: mode for pins 16-31.

  Offsets 0x04 and 0x1C, and any address with nonzero bits [1:0], read as zero and ignore writes. In the function, direction, data and status words, pin n (port p = n/8, bit b = n%8) sits at word bit (3-p)*8+b. Strobe `bus_be[k]` enables word bits 8k+7..8k.
- R3: A direction bit of 1 makes the pin an output and 0 an input; `pin_oe[n]` equals pin n's direction bit. `pin_func[n]` equals pin n's function-select bit.
- R4: A read of the data word returns the output latch for output pins and the synchronised `pin_in` level for input pins. A data write changes only the latch, and the latch is seen on `pin_out`.
- R5: `bus_rdata` is registered. It holds the addressed word in the cycle after `bus_rd` is sampled, and keeps that value until the next read.
- R6: Mode fields select edges as follows: 0 disabled, 1 falling, 2 rising, 3 both. Pin n uses the word at 0x14 for n<16 and the word at 0x18 otherwise. With m = n%16, its field sits at bits ((2m+16) mod 32)+1 and (2m+16) mod 32.
- R7: Suppose `pin_in` changes before rising clock edge k. The pending flag sets at edge k+2, and `irq` rises at edge k+3.
- R8: An edge sets no flag when the pin's mode is 0 or when the mode does not select that edge direction.
- R9: Writing a 1 to a status bit clears that flag. A 0 bit, or a bit in a lane whose strobe is low, leaves the flag unchanged.
- R10: When a qualifying edge and a clearing write hit the same flag in the same cycle, the flag stays set.
- R11: `irq` is the registered OR of all pending flags. It falls one cycle after the last flag clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write request |
| bus_rd | input | 1 | Read request |
| bus_addr | input | 5 | Byte address within the register window |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte-lane write strobes, bit k covers data bits 8k+7..8k |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | 32 | Pad input levels, pin order |
| pin_out | output | 32 | Output latch, pin order |
| pin_oe | output | 32 | Output enables, pin order |
| pin_func | output | 32 | Peripheral function select, pin order |
| irq | output | 1 | Combined edge interrupt |

## Verification
The bench builds the block with its default two synchroniser stages. At that depth the flag lands on the third edge and `irq` on the fourth, so a bench that samples `irq` just before and just after edge k+3 catches any stage that is added or dropped.

The pins under test are chosen to reach every mapping case:
- pin 0 and pin 9 fall in the upper and lower halves of the first mode word;
- pin 23 and pin 30 fall in the upper and lower halves of the second mode word;
- together they cover all four ports in the status lane swap.

The set-versus-clear collision is produced by timing a status write to the exact cycle the synchroniser presents the edge.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  localparam int PINS      = 32;
  localparam int PORT_W    = 8;
  localparam int PORTS     = PINS / PORT_W;
  localparam int DATA_W    = PINS;
  localparam int BYTES     = DATA_W / 8;
  localparam int ADDR_W    = 5;
  localparam int IDX_W     = 3;
  localparam int MODE_W    = 2;
  localparam int MODE_REGS = 2;
  localparam int PER_MODE  = PINS / MODE_REGS;

  typedef enum logic [IDX_W-1:0] {
    RA_FUNC    = 3'd0,
    RA_HOLE    = 3'd1,
    RA_DIR     = 3'd2,
    RA_DATA    = 3'd3,
    RA_STAT    = 3'd4,
    RA_MODE_LO = 3'd5,
    RA_MODE_HI = 3'd6,
    RA_END     = 3'd7
  } reg_idx_e;

  typedef enum logic [MODE_W-1:0] {
    EDGE_OFF  = 2'd0,
    EDGE_FALL = 2'd1,
    EDGE_RISE = 2'd2,
    EDGE_BOTH = 2'd3
  } edge_mode_e;

  // Port p of the pin vector lands in byte lane PORTS-1-p of the word; the
  // mapping is its own inverse, so it serves both directions.
  function automatic logic [DATA_W-1:0] lane_swap(input logic [DATA_W-1:0] v);
    logic [DATA_W-1:0] r;
    for (int p = 0; p < PORTS; p++)
      r[(PORTS-1-p)*PORT_W +: PORT_W] = v[p*PORT_W +: PORT_W];
    return r;
  endfunction

  // Low bit of the mode field for pin index m inside its mode word
  // (half-words swapped so the first port of the pair is on top).
  function automatic int mode_field_pos(input int m);
    return (MODE_W*m + DATA_W/2) % DATA_W;
  endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] raw_i,
  output logic [WIDTH-1:0] lvl_o,
  output logic [WIDTH-1:0] rise_o,
  output logic [WIDTH-1:0] fall_o
);

  for (genvar n = 0; n < WIDTH; n++) begin : g_pin
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        chain_q <= '0;
        prev_q  <= 1'b0;
      end else begin
        chain_q <= {chain_q[STAGES-2:0], raw_i[n]};
        prev_q  <= chain_q[STAGES-1];
      end
    end

    assign lvl_o[n]  = chain_q[STAGES-1];
    assign rise_o[n] = chain_q[STAGES-1] & ~prev_q;
    assign fall_o[n] = ~chain_q[STAGES-1] & prev_q;
  end

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [WIDTH-1:0]        rise_i,
  input  logic [WIDTH-1:0]        fall_i,
  input  logic [MODE_W*WIDTH-1:0] mode_i,
  input  logic [WIDTH-1:0]        clr_i,
  output logic [WIDTH-1:0]        pend_o,
  output logic                    irq_o
);

  logic [WIDTH-1:0] hit;
  logic [WIDTH-1:0] pend_q;

  for (genvar n = 0; n < WIDTH; n++) begin : g_pin
    edge_mode_e md;
    assign md     = edge_mode_e'(mode_i[MODE_W*n +: MODE_W]);
    assign hit[n] = ((md == EDGE_RISE || md == EDGE_BOTH) && rise_i[n]) ||
                    ((md == EDGE_FALL || md == EDGE_BOTH) && fall_i[n]);
  end

  // A new edge outranks a simultaneous write-one-to-clear.
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      irq_o  <= 1'b0;
    end else begin
      pend_q <= (pend_q & ~clr_i) | hit;
      irq_o  <= |pend_q;
    end
  end

  assign pend_o = pend_q;

endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_bank_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic                   rd_en,
  input  logic [IDX_W-1:0]       idx,
  input  logic                   word_ok,
  input  logic [DATA_W-1:0]      wdata,
  input  logic [BYTES-1:0]       be,
  input  logic [PINS-1:0]        lvl,
  input  logic [PINS-1:0]        pend,
  output logic [DATA_W-1:0]      rdata,
  output logic [PINS-1:0]        func_pins,
  output logic [PINS-1:0]        dir_pins,
  output logic [PINS-1:0]        dout_pins,
  output logic [MODE_W*PINS-1:0] mode_pins,
  output logic [PINS-1:0]        clr_pins
);

  logic [DATA_W-1:0] lane_mask;
  logic [DATA_W-1:0] func_w, dir_w, dout_w;
  logic [DATA_W-1:0] mode_w [MODE_REGS];
  logic [DATA_W-1:0] rd_word;
  logic              wr_hit;
  reg_idx_e          sel;

  for (genvar k = 0; k < BYTES; k++) begin : g_lane
    assign lane_mask[8*k +: 8] = {8{be[k]}};
  end

  assign wr_hit = wr_en & word_ok;
  assign sel    = reg_idx_e'(idx);

  function automatic logic [DATA_W-1:0] merge(input logic [DATA_W-1:0] old,
                                              input logic [DATA_W-1:0] nw,
                                              input logic [DATA_W-1:0] msk);
    return (old & ~msk) | (nw & msk);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      func_w <= '0;
      dir_w  <= '0;
      dout_w <= '0;
      for (int r = 0; r < MODE_REGS; r++) mode_w[r] <= '0;
    end else if (wr_hit) begin
      case (sel)
        RA_FUNC:    func_w    <= merge(func_w, wdata, lane_mask);
        RA_DIR:     dir_w     <= merge(dir_w, wdata, lane_mask);
        RA_DATA:    dout_w    <= merge(dout_w, wdata, lane_mask);
        RA_MODE_LO: mode_w[0] <= merge(mode_w[0], wdata, lane_mask);
        RA_MODE_HI: mode_w[1] <= merge(mode_w[1], wdata, lane_mask);
        default: ;
      endcase
    end
  end

  always_comb begin
    case (sel)
      RA_FUNC:    rd_word = func_w;
      RA_DIR:     rd_word = dir_w;
      RA_DATA:    rd_word = (dir_w & dout_w) | (~dir_w & lane_swap(lvl));
      RA_STAT:    rd_word = lane_swap(pend);
      RA_MODE_LO: rd_word = mode_w[0];
      RA_MODE_HI: rd_word = mode_w[1];
      default:    rd_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= word_ok ? rd_word : '0;
  end

  assign clr_pins  = (wr_hit && sel == RA_STAT) ? lane_swap(wdata & lane_mask) : '0;
  assign func_pins = lane_swap(func_w);
  assign dir_pins  = lane_swap(dir_w);
  assign dout_pins = lane_swap(dout_w);

  for (genvar n = 0; n < PINS; n++) begin : g_mode
    localparam int R   = n / PER_MODE;
    localparam int POS = mode_field_pos(n % PER_MODE);
    assign mode_pins[MODE_W*n +: MODE_W] = mode_w[R][POS +: MODE_W];
  end

endmodule

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank
  import gpio_bank_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [BYTES-1:0]  bus_be,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [PINS-1:0]   pin_in,
  output logic [PINS-1:0]   pin_out,
  output logic [PINS-1:0]   pin_oe,
  output logic [PINS-1:0]   pin_func,
  output logic              irq
);

  logic [PINS-1:0]        lvl_w, rise_w, fall_w, pend_w, clr_w;
  logic [MODE_W*PINS-1:0] mode_w;
  logic                   word_ok;

  assign word_ok = (bus_addr[1:0] == 2'b00);

  gpio_in_sync #(
    .WIDTH  (PINS),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk    (clk),
    .rst    (rst),
    .raw_i  (pin_in),
    .lvl_o  (lvl_w),
    .rise_o (rise_w),
    .fall_o (fall_w)
  );

  gpio_regs u_regs (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (bus_wr),
    .rd_en     (bus_rd),
    .idx       (bus_addr[ADDR_W-1:2]),
    .word_ok   (word_ok),
    .wdata     (bus_wdata),
    .be        (bus_be),
    .lvl       (lvl_w),
    .pend      (pend_w),
    .rdata     (bus_rdata),
    .func_pins (pin_func),
    .dir_pins  (pin_oe),
    .dout_pins (pin_out),
    .mode_pins (mode_w),
    .clr_pins  (clr_w)
  );

  gpio_irq_ctrl #(
    .WIDTH (PINS)
  ) u_irq (
    .clk    (clk),
    .rst    (rst),
    .rise_i (rise_w),
    .fall_i (fall_w),
    .mode_i (mode_w),
    .clr_i  (clr_w),
    .pend_o (pend_w),
    .irq_o  (irq)
  );

endmodule

// File: rtl/gpio_edge_bank_chk.sv
module gpio_edge_bank_chk
  import gpio_bank_pkg::*;
(
  input logic                   clk,
  input logic                   rst,
  input logic                   bus_wr,
  input logic [ADDR_W-1:0]      bus_addr,
  input logic [PINS-1:0]        pin_oe,
  input logic [PINS-1:0]        pend,
  input logic [MODE_W*PINS-1:0] mode,
  input logic                   irq
);

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!irq && pin_oe == '0));

  assert_oe_holds_R3: assert property (@(posedge clk) disable iff (rst)
    !$past(bus_wr) |-> $stable(pin_oe));

  for (genvar n = 0; n < PINS; n++) begin : g_pin
    assert_no_set_when_off_R8: assert property (@(posedge clk) disable iff (rst)
      $rose(pend[n]) |-> ($past(mode[MODE_W*n +: MODE_W]) != 2'd0));
  end

  assert_flags_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    !($past(bus_wr) && $past(bus_addr) == 5'h10) |-> ((pend & $past(pend)) == $past(pend)));

  assert_irq_rise_R11: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> ($past(pend) != '0));

  assert_irq_fall_R11: assert property (@(posedge clk) disable iff (rst)
    $fell(irq) |-> ($past(pend) == '0));

endmodule

bind gpio_edge_bank gpio_edge_bank_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .bus_wr   (bus_wr),
  .bus_addr (bus_addr),
  .pin_oe   (pin_oe),
  .pend     (pend_w),
  .mode     (mode_w),
  .irq      (irq)
);

// File: tb/sim_gpio_edge_bank.sv
`timescale 1ns/1ps
module sim_gpio_edge_bank;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pin_in = '0;
  logic [31:0] pin_out, pin_oe, pin_func;
  logic        irq;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  gpio_edge_bank u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_be(bus_be), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .pin_func(pin_func), .irq(irq)
  );

  typedef struct packed {
    logic [4:0]  a;
    logic [3:0]  be;
    logic [31:0] wd;
    logic [31:0] ex;
  } vec_t;

  localparam vec_t VECS [9] = '{
    '{5'h00, 4'hF, 32'hA5A55A5A, 32'hA5A55A5A},
    '{5'h00, 4'h1, 32'hFFFFFFFF, 32'hA5A55AFF},
    '{5'h08, 4'h8, 32'hFFFFFFFF, 32'hFF000000},
    '{5'h08, 4'h6, 32'h00123400, 32'hFF123400},
    '{5'h0C, 4'hF, 32'hFFFFFFFF, 32'hFF123400},
    '{5'h14, 4'hF, 32'h12345678, 32'h12345678},
    '{5'h18, 4'hC, 32'hDEAD0000, 32'hDEAD0000},
    '{5'h04, 4'hF, 32'hFFFFFFFF, 32'h00000000},
    '{5'h1C, 4'hF, 32'hFFFFFFFF, 32'h00000000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d, input logic [3:0] be);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
    @(negedge clk);
    bus_wr = 1'b0; bus_be = '0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    ticks(3);
    rst = 1'b0;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] d;
    @(negedge clk);
    do_reset();

    // R1: reset state at the ports and in every register
    check("R1 pin_oe", pin_oe, 32'h0);
    check("R1 pin_func", pin_func, 32'h0);
    check("R1 pin_out", pin_out, 32'h0);
    check("R1 irq", {31'h0, irq}, 32'h0);
    for (int a = 0; a < 8; a++) begin
      rd(5'(a*4), d);
      check("R1 register read", d, 32'h0);
    end

    // R2/R4/R5 register table walk
    for (int i = 0; i < 9; i++) begin
      wr(VECS[i].a, VECS[i].wd, VECS[i].be);
      rd(VECS[i].a, d);
      check("R2 R5 table readback", d, VECS[i].ex);
    end

    // R3/R4: lane swap on the pin-order outputs
    check("R3 pin_oe", pin_oe, 32'h003412FF);
    check("R3 pin_func", pin_func, 32'hFF5AA5A5);
    check("R4 pin_out", pin_out, 32'hFFFFFFFF);

    // R4: input pins read synchronised level; pin 8 is an input
    pin_in = 32'h00000100;
    ticks(4);
    rd(5'h0C, d);
    check("R4 data mixed", d, 32'hFF133400);
    // R2: misaligned access ignored
    wr(5'h09, 32'h0, 4'hF);
    rd(5'h08, d);
    check("R2 misaligned write", d, 32'hFF123400);

    pin_in = '0;
    do_reset();
    rd(5'h00, d);
    check("R1 function select after reset", d, 32'h0);
    ticks(4);

    // R8: pin 5 with mode 0
    pin_in[5] = 1'b1;
    ticks(5);
    rd(5'h10, d);
    check("R8 disabled pin", d, 32'h0);
    pin_in[5] = 1'b0;
    ticks(5);

    // R6/R7: pin 0 rising (0x14 bits 17:16 = 2)
    wr(5'h14, 32'h00020000, 4'hF);
    pin_in[0] = 1'b1;
    ticks(3);
    check("R7 irq low at k+2", {31'h0, irq}, 32'h0);
    ticks(1);
    check("R7 irq high at k+3", {31'h0, irq}, 32'h1);
    rd(5'h10, d);
    check("R6 pin0 rising status", d, 32'h01000000);
    wr(5'h10, 32'h01000000, 4'hF);
    check("R11 irq one cycle after clear", {31'h0, irq}, 32'h1);
    ticks(1);
    check("R11 irq low", {31'h0, irq}, 32'h0);
    rd(5'h10, d);
    check("R9 cleared", d, 32'h0);
    pin_in[0] = 1'b0;
    ticks(5);
    rd(5'h10, d);
    check("R8 rising-only ignores fall", d, 32'h0);

    // R6: pin 9 falling (0x14 bits 3:2 = 1)
    wr(5'h14, 32'h00020004, 4'hF);
    pin_in[9] = 1'b1;
    ticks(5);
    rd(5'h10, d);
    check("R8 falling-only ignores rise", d, 32'h0);
    pin_in[9] = 1'b0;
    ticks(5);
    rd(5'h10, d);
    check("R6 pin9 falling status", d, 32'h00020000);

    // R9: zero bits and disabled lanes do not clear
    wr(5'h10, 32'h0, 4'hF);
    rd(5'h10, d);
    check("R9 write zero no effect", d, 32'h00020000);
    wr(5'h10, 32'h00020000, 4'hB);
    rd(5'h10, d);
    check("R9 masked lane no effect", d, 32'h00020000);
    wr(5'h10, 32'h00020000, 4'hF);
    rd(5'h10, d);
    check("R9 clear", d, 32'h0);

    // R6: pin 30 both edges (0x18 bits 13:12 = 3)
    wr(5'h18, 32'h00003000, 4'hF);
    pin_in[30] = 1'b1;
    ticks(5);
    rd(5'h10, d);
    check("R6 pin30 rise", d, 32'h00000040);
    wr(5'h10, 32'h00000040, 4'hF);
    pin_in[30] = 1'b0;
    ticks(5);
    rd(5'h10, d);
    check("R6 pin30 fall", d, 32'h00000040);

    // R10: edge and clear in the same cycle, flag stays set
    pin_in[30] = 1'b1;
    ticks(2);
    bus_wr = 1'b1; bus_addr = 5'h10; bus_wdata = 32'h00000040; bus_be = 4'hF;
    @(negedge clk);
    bus_wr = 1'b0; bus_be = '0;
    rd(5'h10, d);
    check("R10 set wins over clear", d, 32'h00000040);
    wr(5'h10, 32'h00000040, 4'hF);

    // R6: pin 23 rising (0x18 bits 31:30 = 2)
    wr(5'h18, 32'h80003000, 4'hF);
    pin_in[23] = 1'b1;
    ticks(5);
    rd(5'h10, d);
    check("R6 pin23 rising status", d, 32'h00008000);
    check("R11 irq with flag", {31'h0, irq}, 32'h1);

    summary();
    $finish;
  end

endmodule